// File: doc/BRIEF.md
# Endpoint configuration header: identifier, command and status dwords

This block holds the first two dwords of the configuration header of one endpoint function. Dword 0 carries the fixed vendor and device identifiers. Dword 1 carries the command register in its lower half and the status register in its upper half. The transaction layer reports error events as single-cycle strobes. Each strobe sets a sticky status bit, and software clears that bit by writing a one to it.

Configuration software reaches the registers through a dword port. The port takes a dword index, a write strobe with write data and four byte enables, and returns read data combinationally from the addressed dword. Reads change no state. Two resets are provided. The hard reset restores everything. The PCIe reset restores only the command and status dword.

Top module: `pcie_cfg_hdr_regs`

## Requirements
- R1: Dword index 0 reads DEVICE_ID in bits 31:16 and VENDOR_ID in bits 15:0. Writes to it have no effect, and only the hard reset initialises it.
- R2: A low on either the PCIe reset or the hard reset clears the command register and all six error status bits. A PCIe reset alone leaves dword 0 unchanged.
- R3: Command bits 0, 1, 2, 6, 8 and 10 are read/write and every other command bit reads 0. Byte enable 0 gates bits 7:0 and byte enable 1 gates bits 15:8.
- R4: Status bit 31 sets when a poisoned request or a poisoned completion is received.
- R5: Status bit 30 sets when an error message is sent while command bit 8 (system-error enable) is 1, and never while that bit is 0.
- R6: Status bit 29 sets on a received Unsupported Request completion. Bit 28 sets on a received Completer Abort completion. Bit 27 sets when the function sends a Completer Abort completion.
- R7: Status bit 24 sets when command bit 6 (parity-error enable) is 1 and either a poisoned completion is received or a poisoned write is sent. It never sets while bit 6 is 0.
- R8: A write to dword 1 clears status bits 31..27 and 24 only where the written data bit is 1 and byte enable 3 is active. A written 0, or byte enable 3 low, leaves the bit unchanged.
- R9: When a set event and a clearing write hit the same status bit in one cycle, the bit ends up set.
- R10: Status bits 26:25, 23:21 and 18:16 read 0 and bit 20 reads 1, whatever is written. Bit 19 reads the live level of the interrupt-pending input.
- R11: Any dword index other than 0 and 1 reads 0, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hard_rst_n | input | 1 | Hard reset, active low, clears every register |
| pcie_rst_n | input | 1 | PCIe reset, active low, clears dword 1 only |
| cfg_addr | input | ADDR_W | Dword index of the access |
| cfg_wr | input | 1 | Write strobe |
| cfg_be | input | 4 | Byte enables for the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data of the addressed dword |
| ev_rx_poison_tlp | input | 1 | A poisoned request was received |
| ev_rx_poison_cpl | input | 1 | A poisoned completion was received |
| ev_tx_poison_wr | input | 1 | The function sent a poisoned write |
| ev_err_msg_sent | input | 1 | A fatal or non-fatal error message was sent |
| ev_rx_cpl_ur | input | 1 | A completion with Unsupported Request status was received |
| ev_rx_cpl_ca | input | 1 | A completion with Completer Abort status was received |
| ev_tx_cpl_ca | input | 1 | The function sent a Completer Abort completion |
| intr_pending | input | 1 | Level: the function has an interrupt pending |

## Verification
The assertions assume that each event strobe lasts exactly one clock and is sampled together with the command enables as they stood before that edge. A write that changes an enable therefore affects only the events of later cycles. The assertions also assume that the interrupt-pending level and the address are stable while read data is observed. The stimulus changes inputs only shortly after a rising edge and holds strobes for a single cycle. Enables are changed in cycles separate from the events they gate, except where the same-cycle ordering is itself under test.

// File: rtl/cfg_hdr_pkg.sv
package cfg_hdr_pkg;

    localparam int unsigned DW_W       = 32;
    localparam int unsigned HALF_W     = DW_W / 2;
    localparam int unsigned BE_W       = DW_W / 8;
    localparam int unsigned ERR_BITS   = 6;

    // command bit positions used by the status logic
    localparam int unsigned CMD_PERR_EN = 6;
    localparam int unsigned CMD_SERR_EN = 8;

    // status bit positions within the upper byte (bits 31:24 of dword 1)
    localparam int unsigned HB_DPE  = 7;
    localparam int unsigned HB_SSE  = 6;
    localparam int unsigned HB_RMA  = 5;
    localparam int unsigned HB_RTA  = 4;
    localparam int unsigned HB_STA  = 3;
    localparam int unsigned HB_MDPE = 0;

    typedef struct packed {
        logic dpe;   // poisoned TLP received
        logic sse;   // error message sent with system-error enable
        logic rma;   // UR completion received
        logic rta;   // CA completion received
        logic sta;   // CA completion sent
        logic mdpe;  // parity error as requester
    } err_bits_t;

    typedef struct packed {
        logic rx_poison_tlp;
        logic rx_poison_cpl;
        logic tx_poison_wr;
        logic err_msg_sent;
        logic rx_cpl_ur;
        logic rx_cpl_ca;
        logic tx_cpl_ca;
    } err_events_t;

endpackage

// File: rtl/cfg_id_dword.sv
module cfg_id_dword
    import cfg_hdr_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID = 16'h1AB3,
    parameter logic [15:0] DEVICE_ID = 16'h70C2
) (
    input  logic            clk,
    input  logic            hard_rst_n,
    output logic [DW_W-1:0] id_dword
);

    typedef struct packed {
        logic [15:0] dev;
        logic [15:0] ven;
    } id_state_t;

    id_state_t id_d, id_q;

    always_comb begin
        id_d = id_q;
    end

    always_ff @(posedge clk or negedge hard_rst_n) begin
        if (!hard_rst_n) begin
            id_q <= '{dev: DEVICE_ID, ven: VENDOR_ID};
        end else begin
            id_q <= id_d;
        end
    end

    assign id_dword = {id_q.dev, id_q.ven};

endmodule

// File: rtl/cfg_cmd_reg.sv
module cfg_cmd_reg
    import cfg_hdr_pkg::*;
#(
    parameter logic [15:0] RW_MASK = 16'h0547
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        be,
    input  logic [HALF_W-1:0] wdata,
    output logic [HALF_W-1:0] cmd
);

    localparam int unsigned NBYTES = HALF_W / 8;

    typedef struct packed {
        logic [HALF_W-1:0] bits;
    } cmd_state_t;

    cmd_state_t cmd_d, cmd_q;
    logic [HALF_W-1:0] wmask;

    generate
        for (genvar b = 0; b < NBYTES; b++) begin : g_byte
            assign wmask[b*8 +: 8] = {8{wr_en & be[b]}} & RW_MASK[b*8 +: 8];
        end
    endgenerate

    always_comb begin
        cmd_d      = cmd_q;
        cmd_d.bits = (cmd_q.bits & ~wmask) | (wdata & wmask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q <= '0;
        end else begin
            cmd_q <= cmd_d;
        end
    end

    assign cmd = cmd_q.bits;

endmodule

// File: rtl/cfg_err_status.sv
module cfg_err_status
    import cfg_hdr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        be_hi,
    input  logic [7:0]  wdata_hi,
    input  err_events_t ev,
    input  logic        serr_en,
    input  logic        perr_en,
    output err_bits_t   err
);

    typedef struct packed {
        err_bits_t flags;
    } err_state_t;

    err_state_t err_d, err_q;
    err_bits_t  set_v, clr_v;

    always_comb begin
        set_v.dpe  = ev.rx_poison_tlp | ev.rx_poison_cpl;
        set_v.sse  = ev.err_msg_sent & serr_en;
        set_v.rma  = ev.rx_cpl_ur;
        set_v.rta  = ev.rx_cpl_ca;
        set_v.sta  = ev.tx_cpl_ca;
        set_v.mdpe = perr_en & (ev.rx_poison_cpl | ev.tx_poison_wr);
    end

    always_comb begin
        clr_v = '0;
        if (wr_en && be_hi) begin
            clr_v.dpe  = wdata_hi[HB_DPE];
            clr_v.sse  = wdata_hi[HB_SSE];
            clr_v.rma  = wdata_hi[HB_RMA];
            clr_v.rta  = wdata_hi[HB_RTA];
            clr_v.sta  = wdata_hi[HB_STA];
            clr_v.mdpe = wdata_hi[HB_MDPE];
        end
    end

    always_comb begin
        err_d       = err_q;
        err_d.flags = (err_q.flags & ~clr_v) | set_v;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q <= '0;
        end else begin
            err_q <= err_d;
        end
    end

    assign err = err_q.flags;

endmodule

// File: rtl/pcie_cfg_hdr_regs.sv
module pcie_cfg_hdr_regs
    import cfg_hdr_pkg::*;
#(
    parameter int unsigned ADDR_W    = 10,
    parameter logic [15:0] VENDOR_ID = 16'h1AB3,
    parameter logic [15:0] DEVICE_ID = 16'h70C2,
    parameter logic [15:0] CMD_MASK  = 16'h0547
) (
    input  logic              clk,
    input  logic              hard_rst_n,
    input  logic              pcie_rst_n,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic              cfg_wr,
    input  logic [3:0]        cfg_be,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              ev_rx_poison_tlp,
    input  logic              ev_rx_poison_cpl,
    input  logic              ev_tx_poison_wr,
    input  logic              ev_err_msg_sent,
    input  logic              ev_rx_cpl_ur,
    input  logic              ev_rx_cpl_ca,
    input  logic              ev_tx_cpl_ca,
    input  logic              intr_pending
);

    localparam logic [ADDR_W-1:0] IDX_ID  = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] IDX_CS  = ADDR_W'(1);

    logic              cs_rst_n;
    logic              wr_cs;
    logic [DW_W-1:0]   id_dword;
    logic [HALF_W-1:0] cmd;
    logic [HALF_W-1:0] status;
    err_bits_t         err_bits;
    err_events_t       ev;
    logic              unused_wbits;

    assign cs_rst_n     = hard_rst_n & pcie_rst_n;
    assign wr_cs        = cfg_wr & (cfg_addr == IDX_CS);
    assign unused_wbits = ^{cfg_wdata[23:16], cfg_be[2]};

    assign ev = '{rx_poison_tlp: ev_rx_poison_tlp,
                  rx_poison_cpl: ev_rx_poison_cpl,
                  tx_poison_wr:  ev_tx_poison_wr,
                  err_msg_sent:  ev_err_msg_sent,
                  rx_cpl_ur:     ev_rx_cpl_ur,
                  rx_cpl_ca:     ev_rx_cpl_ca,
                  tx_cpl_ca:     ev_tx_cpl_ca};

    cfg_id_dword #(
        .VENDOR_ID (VENDOR_ID),
        .DEVICE_ID (DEVICE_ID)
    ) u_id (
        .clk        (clk),
        .hard_rst_n (hard_rst_n),
        .id_dword   (id_dword)
    );

    cfg_cmd_reg #(
        .RW_MASK (CMD_MASK)
    ) u_cmd (
        .clk   (clk),
        .rst_n (cs_rst_n),
        .wr_en (wr_cs),
        .be    (cfg_be[1:0]),
        .wdata (cfg_wdata[15:0]),
        .cmd   (cmd)
    );

    cfg_err_status u_err (
        .clk      (clk),
        .rst_n    (cs_rst_n),
        .wr_en    (wr_cs),
        .be_hi    (cfg_be[3]),
        .wdata_hi (cfg_wdata[31:24]),
        .ev       (ev),
        .serr_en  (cmd[CMD_SERR_EN]),
        .perr_en  (cmd[CMD_PERR_EN]),
        .err      (err_bits)
    );

    // upper half of dword 1, bit 31 first
    assign status = {err_bits.dpe, err_bits.sse, err_bits.rma, err_bits.rta,
                     err_bits.sta, 2'b00, err_bits.mdpe,
                     3'b000, 1'b1, intr_pending, 3'b000};

    always_comb begin
        unique case (cfg_addr)
            IDX_ID:  cfg_rdata = id_dword;
            IDX_CS:  cfg_rdata = {status, cmd};
            default: cfg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/cfg_hdr_chk.sv
module cfg_hdr_chk #(
    parameter int unsigned ADDR_W    = 10,
    parameter logic [15:0] VENDOR_ID = 16'h1AB3,
    parameter logic [15:0] DEVICE_ID = 16'h70C2
) (
    input logic              clk,
    input logic              hard_rst_n,
    input logic              cs_rst_n,
    input logic [ADDR_W-1:0] cfg_addr,
    input logic [31:0]       cfg_rdata,
    input logic              wr_cs,
    input logic [15:0]       cmd,
    input logic [5:0]        err,
    input logic [6:0]        ev,
    input logic              ev_rx_cpl_ur,
    input logic              intr_pending
);

    AST_ID_READ: assert property (@(posedge clk) disable iff (!hard_rst_n)
        (cfg_addr == ADDR_W'(0)) |-> (cfg_rdata == {DEVICE_ID, VENDOR_ID})); // R1

    AST_SERR_GATE: assert property (@(posedge clk) disable iff (!cs_rst_n)
        (!cmd[8] && !err[4]) |=> !err[4]); // R5

    AST_MDPE_GATE: assert property (@(posedge clk) disable iff (!cs_rst_n)
        (!cmd[6] && !err[0]) |=> !err[0]); // R7

    AST_UR_SETS: assert property (@(posedge clk) disable iff (!cs_rst_n)
        ev_rx_cpl_ur |=> err[3]); // R9

    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!cs_rst_n)
        (ev == 7'd0 && !wr_cs) |=> $stable(err)); // R8

    AST_INTR_LIVE: assert property (@(posedge clk) disable iff (!cs_rst_n)
        (cfg_addr == ADDR_W'(1)) |-> (cfg_rdata[19] == intr_pending && cfg_rdata[20])); // R10

endmodule

bind pcie_cfg_hdr_regs cfg_hdr_chk #(
    .ADDR_W    (ADDR_W),
    .VENDOR_ID (VENDOR_ID),
    .DEVICE_ID (DEVICE_ID)
) u_chk (
    .clk          (clk),
    .hard_rst_n   (hard_rst_n),
    .cs_rst_n     (cs_rst_n),
    .cfg_addr     (cfg_addr),
    .cfg_rdata    (cfg_rdata),
    .wr_cs        (wr_cs),
    .cmd          (cmd),
    .err          (err_bits),
    .ev           (ev),
    .ev_rx_cpl_ur (ev_rx_cpl_ur),
    .intr_pending (intr_pending)
);

// File: tb/pcie_cfg_hdr_regs_bench.sv
`timescale 1ns/1ps
module pcie_cfg_hdr_regs_bench;

    localparam int unsigned ADDR_W = 10;
    localparam logic [15:0] VEN    = 16'h1AB3;
    localparam logic [15:0] DEV    = 16'h70C2;
    localparam int unsigned NVEC   = 16;

    logic              clk = 1'b0;
    logic              hard_rst_n = 1'b0;
    logic              pcie_rst_n = 1'b0;
    logic [ADDR_W-1:0] cfg_addr = '0;
    logic              cfg_wr = 1'b0;
    logic [3:0]        cfg_be = '0;
    logic [31:0]       cfg_wdata = '0;
    logic [31:0]       cfg_rdata;
    logic [6:0]        ev = '0;  // {tx_cpl_ca, rx_cpl_ca, rx_cpl_ur, err_msg, tx_poison_wr, rx_poison_cpl, rx_poison_tlp}
    logic              intr_pending = 1'b0;
    int                checks = 0;
    int                errors = 0;

    always #4 clk = ~clk;

    pcie_cfg_hdr_regs #(.ADDR_W(ADDR_W), .VENDOR_ID(VEN), .DEVICE_ID(DEV)) u_pcie_cfg_hdr_regs (
        .clk              (clk),
        .hard_rst_n       (hard_rst_n),
        .pcie_rst_n       (pcie_rst_n),
        .cfg_addr         (cfg_addr),
        .cfg_wr           (cfg_wr),
        .cfg_be           (cfg_be),
        .cfg_wdata        (cfg_wdata),
        .cfg_rdata        (cfg_rdata),
        .ev_rx_poison_tlp (ev[0]),
        .ev_rx_poison_cpl (ev[1]),
        .ev_tx_poison_wr  (ev[2]),
        .ev_err_msg_sent  (ev[3]),
        .ev_rx_cpl_ur     (ev[4]),
        .ev_rx_cpl_ca     (ev[5]),
        .ev_tx_cpl_ca     (ev[6]),
        .intr_pending     (intr_pending)
    );

    // {events[6:0], wr, be[3:0], wdata[31:0], expected dword 1}; all writes go to dword 1
    localparam logic [75:0] VEC [NVEC] = '{
        {7'h00, 1'b1, 4'h3, 32'h0000_0547, 32'h0010_0547},  // 0  R3 set command bits
        {7'h10, 1'b0, 4'h0, 32'h0,         32'h2010_0547},  // 1  R6 UR received
        {7'h20, 1'b0, 4'h0, 32'h0,         32'h3010_0547},  // 2  R6 CA received
        {7'h40, 1'b0, 4'h0, 32'h0,         32'h3810_0547},  // 3  R6 CA sent
        {7'h08, 1'b0, 4'h0, 32'h0,         32'h7810_0547},  // 4  R5 message, enable on
        {7'h02, 1'b0, 4'h0, 32'h0,         32'hF910_0547},  // 5  R7 R4 poisoned completion
        {7'h00, 1'b1, 4'h8, 32'h2000_0000, 32'hD910_0547},  // 6  R8 clear bit 29
        {7'h00, 1'b1, 4'h4, 32'hFFFF_0000, 32'hD910_0547},  // 7  R10 byte 2 write ignored
        {7'h10, 1'b1, 4'h8, 32'hFF00_0000, 32'h2010_0547},  // 8  R9 set wins
        {7'h00, 1'b1, 4'h1, 32'h0000_0000, 32'h2010_0500},  // 9  R3 low byte only
        {7'h04, 1'b0, 4'h0, 32'h0,         32'h2010_0500},  // 10 R7 parity enable off
        {7'h01, 1'b0, 4'h0, 32'h0,         32'hA010_0500},  // 11 R4 poisoned request
        {7'h00, 1'b1, 4'h2, 32'h0000_0000, 32'hA010_0000},  // 12 R3 high byte only
        {7'h08, 1'b0, 4'h0, 32'h0,         32'hA010_0000},  // 13 R5 message, enable off
        {7'h00, 1'b1, 4'hF, 32'hFFFF_FFFF, 32'h0010_0547},  // 14 R10 R8 all ones
        {7'h04, 1'b0, 4'h0, 32'h0,         32'h0110_0547}   // 15 R7 poisoned write sent
    };

    function automatic string vec_tag(int i);
        case (i)
            0, 9, 12: return "R3";
            1, 2, 3:  return "R6";
            4, 13:    return "R5";
            5, 10, 15: return "R7";
            6:        return "R8";
            8:        return "R9";
            11:       return "R4";
            default:  return "R10";
        endcase
    endfunction

    task automatic apply(input logic [6:0] e, input logic w, input logic [3:0] be,
                         input logic [ADDR_W-1:0] a, input logic [31:0] d);
        ev = e; cfg_wr = w; cfg_be = be; cfg_addr = a; cfg_wdata = d;
        @(posedge clk);
        #2;
        ev = '0; cfg_wr = 1'b0; cfg_be = '0; cfg_wdata = '0;
    endtask

    task automatic check_rd(input logic [ADDR_W-1:0] a, input logic [31:0] exp, input string tag);
        cfg_addr = a;
        #1;
        checks++;
        if (cfg_rdata !== exp) begin
            errors++;
            $display("FAIL %s: dword %0d read %h, expected %h", tag, a, cfg_rdata, exp);
        end
    endtask

    initial begin
        #(200000 * 8);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not finish, actual timeout, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        hard_rst_n = 1'b1;
        pcie_rst_n = 1'b1;
        @(posedge clk);
        #2;
        check_rd(0, {DEV, VEN}, "R1 reset");
        check_rd(1, 32'h0010_0000, "R2 reset");

        for (int i = 0; i < NVEC; i++) begin
            apply(VEC[i][75:69], VEC[i][68], VEC[i][67:64], 1, VEC[i][63:32]);
            check_rd(1, VEC[i][31:0], vec_tag(i));
        end

        // R1: identifier write ignored
        apply(7'h00, 1'b1, 4'hF, 0, 32'hFFFF_FFFF);
        check_rd(0, {DEV, VEN}, "R1 write");

        // R10: interrupt level seen live
        intr_pending = 1'b1;
        check_rd(1, 32'h0118_0547, "R10 intr");
        intr_pending = 1'b0;
        check_rd(1, 32'h0110_0547, "R10 intr clear");

        // R11: other dword index
        apply(7'h00, 1'b1, 4'hF, 2, 32'hFFFF_FFFF);
        check_rd(2, 32'h0, "R11 read");
        check_rd(1, 32'h0110_0547, "R11 no effect");

        // R2: PCIe reset clears dword 1 only
        pcie_rst_n = 1'b0;
        @(posedge clk);
        #2;
        pcie_rst_n = 1'b1;
        @(posedge clk);
        #2;
        check_rd(1, 32'h0010_0000, "R2 pcie reset");
        check_rd(0, {DEV, VEN}, "R2 id kept");

        // R8: byte enable 3 low, or data bit 0, keeps the flag
        apply(7'h10, 1'b0, 4'h0, 1, 32'h0);
        check_rd(1, 32'h2010_0000, "R6 UR after reset");
        apply(7'h00, 1'b1, 4'h7, 1, 32'h2000_0000);
        check_rd(1, 32'h2010_0000, "R8 be3 low");
        apply(7'h00, 1'b1, 4'h8, 1, 32'h0000_0000);
        check_rd(1, 32'h2010_0000, "R8 zero data");

        // R5: message while enable is being set in the same cycle is not counted
        apply(7'h08, 1'b1, 4'h2, 1, 32'h0000_0100);
        check_rd(1, 32'h2010_0100, "R5 enable same cycle");
        apply(7'h08, 1'b0, 4'h0, 1, 32'h0);
        check_rd(1, 32'h6010_0100, "R5 enable set");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule